// File: doc/BRIEF.md
# Latching-Relay Power Sequencer

This controller brings a bistable relay module and an amplifier up and down in a fixed order, driven by an 8-bit sample of the supply rail and a slow periodic tick (about 0.1 s per tick). After a charge-up wait, it pulses the relay's SET coil. It then waits for the contacts to settle before enabling the amplifier. When the supply sags, it drops the amplifier enable and pulses the relay's RESET coil. Because the relay latches, each coil only needs a timed pulse. The two coils must never be driven at the same time.

The decision logic runs only on cycles that carry a valid supply sample. A sample at or below the undervoltage level counts as a collapse event. Two tick counters measure the waits. Both saturate at their maximum value instead of wrapping. One counter measures how long the supply has stayed healthy. The other measures dwell time inside the current stage. Each state responds only to the events defined for it. Every other event is ignored.

Top module: `relay_power_sequencer`

## Requirements
- R1: While and after a synchronous reset, the controller is in the off stage and set_coil_o, reset_coil_o and amp_en_o are all low.
- R2: A valid sample with a value of 217 or less is an undervoltage event. A valid sample of 218 or more is not.
- R3: In the off stage, on a valid cycle where the healthy-time counter holds 10 ticks or more, the controller raises set_coil_o (with reset_coil_o low) from the next cycle onward and enters the set-pulse stage.
- R4: In the set-pulse stage, on a valid cycle where the dwell counter (cleared on entry) holds 10 or more ticks, set_coil_o drops and the controller enters the plugged stage.
- R5: In the plugged stage, on a valid cycle where the dwell counter holds 35 or more ticks, amp_en_o rises and the controller enters the idle stage.
- R6: An undervoltage event in the set-pulse, plugged or idle stage drives set_coil_o and amp_en_o low and reset_coil_o high, and enters the reset-pulse stage with the dwell counter cleared.
- R7: In the reset-pulse stage, on a valid cycle where the dwell counter holds 10 or more ticks, reset_coil_o drops and the controller returns to the off stage.
- R8: Undervoltage events cause no transition in the off stage or the reset-pulse stage.
- R9: Every undervoltage event clears the healthy-time counter. The off stage advances only after 10 ticks with no undervoltage event in between.
- R10: At most one transition happens per cycle. A timer event defined for the current stage takes precedence over a simultaneous undervoltage event.
- R11: On cycles without sample_vld_i, nothing changes state, whatever the sample and counter values are.
- R12: Both tick counters saturate at 255 instead of wrapping. For example, 261 ticks still count as at least 10.
- R13: set_coil_o and reset_coil_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_i | input | 8 | Supply voltage sample (255 is about 3.4 V) |
| sample_vld_i | input | 1 | Marks a cycle carrying a fresh sample; events are evaluated only then |
| tick_i | input | 1 | One-cycle pulse per time-base period |
| set_coil_o | output | 1 | Relay SET coil drive |
| reset_coil_o | output | 1 | Relay RESET coil drive |
| amp_en_o | output | 1 | Amplifier enable |

## Verification
The hardest conditions to reach are the counter corners, because the counters are invisible at the ports. Two of them are a saturated counter and a timer event that lands on the same valid cycle as an undervoltage sample. The stimulus sends long runs of ticks with no valid strobe: 261 ticks would wrap an 8-bit counter to 5 but not a saturating one. It then issues a single valid sample, so the outcome at the ports shows which behaviour happened. To test precedence, the bench fills a dwell counter with bare ticks and then presents a low sample on the first valid cycle. A long pseudo-random phase with rare, near-threshold low samples is checked against an arithmetic model cycle by cycle. This phase reaches the idle stage and collapses from every stage.

// File: rtl/rps_pkg.sv
package rps_pkg;

    typedef enum logic [2:0] {
        ST_OFF         = 3'd0,
        ST_SET_PULSE   = 3'd1,
        ST_PLUG_ON     = 3'd2,
        ST_IDLE        = 3'd3,
        ST_RESET_PULSE = 3'd4
    } rps_state_e;

    typedef struct packed {
        rps_state_e state;
        logic       set_coil;
        logic       reset_coil;
        logic       amp_en;
    } rps_ctrl_s;

    localparam rps_ctrl_s CTRL_RST = '{
        state:      ST_OFF,
        set_coil:   1'b0,
        reset_coil: 1'b0,
        amp_en:     1'b0
    };

endpackage

// File: rtl/rps_sat_counter.sv
module rps_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] count_o
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/rps_uv_detect.sv
module rps_uv_detect #(
    parameter int W        = 8,
    parameter int UV_LEVEL = 217
) (
    input  logic [W-1:0] sample_i,
    input  logic         sample_vld_i,
    output logic         uv_o
);
    localparam logic [W-1:0] LEVEL_V = W'(UV_LEVEL);

    assign uv_o = sample_vld_i && (sample_i <= LEVEL_V);
endmodule

// File: rtl/rps_seq_fsm.sv
module rps_seq_fsm
    import rps_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int CHARGE_TICKS = 10,
    parameter int DWELL1_TICKS = 10,
    parameter int DWELL2_TICKS = 35
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             eval_i,
    input  logic             uv_i,
    input  logic [CNT_W-1:0] charge_cnt_i,
    input  logic [CNT_W-1:0] sleep_cnt_i,
    output logic             sleep_clr_o,
    output logic             set_coil_o,
    output logic             reset_coil_o,
    output logic             amp_en_o
);
    localparam logic [CNT_W-1:0] CHARGE_LIM = CNT_W'(CHARGE_TICKS);
    localparam logic [CNT_W-1:0] DWELL1_LIM = CNT_W'(DWELL1_TICKS);
    localparam logic [CNT_W-1:0] DWELL2_LIM = CNT_W'(DWELL2_TICKS);

    rps_ctrl_s ctrl_d, ctrl_q;
    logic      sleep_clr_d;
    logic      charge_done, dwell1_done, dwell2_done;

    assign charge_done = charge_cnt_i >= CHARGE_LIM;
    assign dwell1_done = sleep_cnt_i  >= DWELL1_LIM;
    assign dwell2_done = sleep_cnt_i  >= DWELL2_LIM;

    // Timer events are tested before undervoltage; one transition per cycle.
    always_comb begin
        ctrl_d      = ctrl_q;
        sleep_clr_d = 1'b0;
        if (eval_i) begin
            unique case (ctrl_q.state)
                ST_OFF: begin
                    if (charge_done) begin
                        ctrl_d.reset_coil = 1'b0;
                        ctrl_d.set_coil   = 1'b1;
                        ctrl_d.state      = ST_SET_PULSE;
                        sleep_clr_d       = 1'b1;
                    end
                end
                ST_SET_PULSE: begin
                    if (dwell1_done) begin
                        ctrl_d.set_coil = 1'b0;
                        ctrl_d.state    = ST_PLUG_ON;
                        sleep_clr_d     = 1'b1;
                    end else if (uv_i) begin
                        ctrl_d.set_coil   = 1'b0;
                        ctrl_d.amp_en     = 1'b0;
                        ctrl_d.reset_coil = 1'b1;
                        ctrl_d.state      = ST_RESET_PULSE;
                        sleep_clr_d       = 1'b1;
                    end
                end
                ST_PLUG_ON: begin
                    if (dwell2_done) begin
                        ctrl_d.amp_en = 1'b1;
                        ctrl_d.state  = ST_IDLE;
                    end else if (uv_i) begin
                        ctrl_d.set_coil   = 1'b0;
                        ctrl_d.amp_en     = 1'b0;
                        ctrl_d.reset_coil = 1'b1;
                        ctrl_d.state      = ST_RESET_PULSE;
                        sleep_clr_d       = 1'b1;
                    end
                end
                ST_IDLE: begin
                    if (uv_i) begin
                        ctrl_d.set_coil   = 1'b0;
                        ctrl_d.amp_en     = 1'b0;
                        ctrl_d.reset_coil = 1'b1;
                        ctrl_d.state      = ST_RESET_PULSE;
                        sleep_clr_d       = 1'b1;
                    end
                end
                ST_RESET_PULSE: begin
                    if (dwell1_done) begin
                        ctrl_d.reset_coil = 1'b0;
                        ctrl_d.state      = ST_OFF;
                    end
                end
                default: begin
                    ctrl_d = CTRL_RST;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign sleep_clr_o  = sleep_clr_d;
    assign set_coil_o   = ctrl_q.set_coil;
    assign reset_coil_o = ctrl_q.reset_coil;
    assign amp_en_o     = ctrl_q.amp_en;
endmodule

// File: rtl/relay_power_sequencer.sv
module relay_power_sequencer #(
    parameter int SAMPLE_W     = 8,
    parameter int CNT_W        = 8,
    parameter int UV_LEVEL     = 217,
    parameter int CHARGE_TICKS = 10,
    parameter int DWELL1_TICKS = 10,
    parameter int DWELL2_TICKS = 35
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                sample_vld_i,
    input  logic                tick_i,
    output logic                set_coil_o,
    output logic                reset_coil_o,
    output logic                amp_en_o
);
    logic             uv_evt;
    logic             sleep_clr;
    logic [CNT_W-1:0] charge_cnt;
    logic [CNT_W-1:0] sleep_cnt;

    rps_uv_detect #(
        .W        (SAMPLE_W),
        .UV_LEVEL (UV_LEVEL)
    ) u_uv (
        .sample_i     (sample_i),
        .sample_vld_i (sample_vld_i),
        .uv_o         (uv_evt)
    );

    // healthy-supply time: cleared by every undervoltage sample
    rps_sat_counter #(.W(CNT_W)) u_charge_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (uv_evt),
        .inc_i   (tick_i),
        .count_o (charge_cnt)
    );

    // dwell time inside the current stage
    rps_sat_counter #(.W(CNT_W)) u_sleep_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (sleep_clr),
        .inc_i   (tick_i),
        .count_o (sleep_cnt)
    );

    rps_seq_fsm #(
        .CNT_W        (CNT_W),
        .CHARGE_TICKS (CHARGE_TICKS),
        .DWELL1_TICKS (DWELL1_TICKS),
        .DWELL2_TICKS (DWELL2_TICKS)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .eval_i       (sample_vld_i),
        .uv_i         (uv_evt),
        .charge_cnt_i (charge_cnt),
        .sleep_cnt_i  (sleep_cnt),
        .sleep_clr_o  (sleep_clr),
        .set_coil_o   (set_coil_o),
        .reset_coil_o (reset_coil_o),
        .amp_en_o     (amp_en_o)
    );
endmodule

// File: rtl/rps_checker.sv
module rps_checker #(
    parameter int SAMPLE_W = 8,
    parameter int UV_LEVEL = 217
) (
    input logic                clk,
    input logic                rst,
    input logic [SAMPLE_W-1:0] sample_i,
    input logic                sample_vld_i,
    input logic                set_coil_o,
    input logic                reset_coil_o,
    input logic                amp_en_o
);
    localparam logic [SAMPLE_W-1:0] LEVEL_V = SAMPLE_W'(UV_LEVEL);

    // R13
    coil_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(set_coil_o && reset_coil_o));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!set_coil_o && !reset_coil_o && !amp_en_o));

    // R11
    hold_without_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_vld_i |=> ($stable(set_coil_o) && $stable(reset_coil_o) && $stable(amp_en_o)));

    // R3
    set_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(set_coil_o) |-> ($past(sample_vld_i) && !$past(reset_coil_o) && !$past(amp_en_o)));

    // R6
    reset_needs_uv_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(reset_coil_o) |-> ($past(sample_vld_i) && ($past(sample_i) <= LEVEL_V)));

    // R6
    amp_coil_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(amp_en_o && (set_coil_o || reset_coil_o)));
endmodule

bind relay_power_sequencer rps_checker #(
    .SAMPLE_W (SAMPLE_W),
    .UV_LEVEL (UV_LEVEL)
) u_rps_chk (
    .clk          (clk),
    .rst          (rst),
    .sample_i     (sample_i),
    .sample_vld_i (sample_vld_i),
    .set_coil_o   (set_coil_o),
    .reset_coil_o (reset_coil_o),
    .amp_en_o     (amp_en_o)
);

// File: tb/tb_relay_power_sequencer.sv
module tb_relay_power_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int GOOD = 230;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] smp = 8'd240;
    logic       vld = 1'b0;
    logic       tk  = 1'b0;
    logic       set_o, rst_o, amp_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // reference model state: 0 off,1 set,2 plug,3 idle,4 reset-pulse
    int m_st = 0, m_chg = 0, m_slp = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #(CLK_PERIOD/2) clk = ~clk;

    relay_power_sequencer dut (
        .clk          (clk),
        .rst          (rst),
        .sample_i     (smp),
        .sample_vld_i (vld),
        .tick_i       (tk),
        .set_coil_o   (set_o),
        .reset_coil_o (rst_o),
        .amp_en_o     (amp_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v > 255) ? 255 : v;
    endfunction

    task automatic model_step(input bit r, input bit v, input int s, input bit t);
        bit uv, clr;
        int nst;
        uv  = v && (s <= 217);
        clr = 0;
        nst = m_st;
        if (r) begin
            m_st = 0; m_chg = 0; m_slp = 0;
            return;
        end
        if (v) begin
            case (m_st)
                0: if (m_chg >= 10) begin nst = 1; clr = 1; end
                1: if (m_slp >= 10) begin nst = 2; clr = 1; end
                   else if (uv) begin nst = 4; clr = 1; end
                2: if (m_slp >= 35) nst = 3;
                   else if (uv) begin nst = 4; clr = 1; end
                3: if (uv) begin nst = 4; clr = 1; end
                default: if (m_slp >= 10) nst = 0;
            endcase
        end
        m_chg = uv  ? 0 : (t ? sat(m_chg + 1) : m_chg);
        m_slp = clr ? 0 : (t ? sat(m_slp + 1) : m_slp);
        m_st  = nst;
    endtask

    task automatic step(input bit v, input int s, input bit t);
        int exp_o, act_o;
        vld = v; smp = 8'(s); tk = t;
        @(posedge clk);
        #1;
        model_step(rst, v, s, t);
        exp_o = {29'd0, m_st == 1, m_st == 4, m_st == 3};
        act_o = {29'd0, set_o, rst_o, amp_o};
        if (exp_o[2] != act_o[2]) chk(0, "R3 set coil vs model", act_o, exp_o);
        else if (exp_o[1] != act_o[1]) chk(0, "R6 reset coil vs model", act_o, exp_o);
        else chk(exp_o[0] == act_o[0], "R5 amp enable vs model", act_o, exp_o);
        chk(!(set_o && rst_o), "R13 coils overlap", {set_o, rst_o}, 0);
        vld = 0; tk = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(0, 8, 1);
    endtask

    task automatic eval(input int s);
        step(1, s, 0);
    endtask

    task automatic expect_out(input string tag, input bit es, input bit er, input bit ea);
        chk({set_o, rst_o, amp_o} == {es, er, ea}, tag, {set_o, rst_o, amp_o}, {es, er, ea});
    endtask

    task automatic do_reset();
        rst = 1;
        step(0, GOOD, 0);
        step(1, 0, 1);
        rst = 0;
    endtask

    initial begin
        // R1: reset state
        do_reset();
        expect_out("R1 outputs after reset", 0, 0, 0);

        // R11: timeouts pass without a valid strobe, low samples with vld low
        ticks(12);
        step(0, 0, 0);
        expect_out("R11 no transition without valid", 0, 0, 0);
        eval(GOOD);
        expect_out("R3 set pulse starts", 1, 0, 0);

        // R4: first dwell
        ticks(9); eval(GOOD);
        expect_out("R4 set held at 9 ticks", 1, 0, 0);
        ticks(1); eval(GOOD);
        expect_out("R4 set released at 10 ticks", 0, 0, 0);

        // R5: second dwell
        ticks(34); eval(GOOD);
        expect_out("R5 amp low at 34 ticks", 0, 0, 0);
        ticks(1); eval(GOOD);
        expect_out("R5 amp high at 35 ticks", 0, 0, 1);

        // R2: threshold edge in idle
        eval(218);
        expect_out("R2 sample 218 is healthy", 0, 0, 1);
        eval(255);
        expect_out("R2 sample 255 is healthy", 0, 0, 1);
        eval(217);
        expect_out("R6 collapse from idle at 217", 0, 1, 0);

        // R8 / R7: reset pulse ignores undervoltage, ends after 10 ticks
        eval(0);
        expect_out("R8 uv ignored in reset pulse", 0, 1, 0);
        ticks(9); eval(100);
        expect_out("R7 reset held at 9 ticks", 0, 1, 0);
        ticks(1); eval(100);
        expect_out("R7 reset released at 10 ticks", 0, 0, 0);

        // R9 / R8: interrupted charge in off
        ticks(9); eval(5);
        expect_out("R8 uv ignored in off", 0, 0, 0);
        ticks(9); eval(GOOD);
        expect_out("R9 charge restarted by uv", 0, 0, 0);
        ticks(1); eval(GOOD);
        expect_out("R9 charge complete", 1, 0, 0);

        // R10: dwell beats simultaneous undervoltage
        ticks(10); eval(0);
        expect_out("R10 dwell wins over uv", 0, 0, 0);
        eval(0);
        expect_out("R6 collapse from plugged", 0, 1, 0);
        ticks(10); eval(GOOD);
        expect_out("R7 back to off", 0, 0, 0);

        // R10: charge timeout in off wins over uv on the same cycle
        eval(3);
        expect_out("R10 charge timeout beats uv", 1, 0, 0);
        eval(3);
        expect_out("R6 collapse from set pulse", 0, 1, 0);
        ticks(10); eval(GOOD);

        // R12: saturation of both counters
        do_reset();
        ticks(261); eval(GOOD);
        expect_out("R12 charge counter saturates", 1, 0, 0);
        ticks(261); eval(GOOD);
        expect_out("R12 sleep counter saturates", 0, 0, 0);
        ticks(40); eval(GOOD);
        expect_out("R5 idle after saturated stage", 0, 0, 1);

        // pseudo-random sweep against the model (all requirements)
        do_reset();
        for (int i = 0; i < 80000; i++) begin
            bit v, t;
            int s, rate;
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            rate = (i < 40000) ? 10 : 7;
            v = lfsr[0] | lfsr[1];
            t = (lfsr[4:2] == 3'd0);
            s = ((lfsr[31:22] >> (10 - rate)) == 0) ? (200 + int'(lfsr[20:16])) : 240;
            step(v, s, t);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog expired: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule